// File: doc/BRIEF.md
# Accumulator rotate and flag-control unit

This unit performs the one-byte operations of an 8-bit CPU that touch only the accumulator and the flag byte. There are four accumulator rotates (circular and through-carry, in each direction), a bitwise complement of the accumulator, a forced carry set and a carry complement. The decode stage presents the current accumulator, the current flag byte and a 3-bit operation code, together with a valid strobe. On the clock edge where the strobe is high, the unit registers the new accumulator and the new flag byte. It then holds them until the next strobe.

Each operation writes only its own subset of flags. Sign, zero and parity/overflow always pass through untouched, so flag state left by earlier ALU operations survives. The flag byte uses the same bit layout as the CPU's ALU. The bit positions are: bit 0 carry (C), bit 1 subtract (N), bit 2 parity/overflow (PV), bit 3 copy bit (X), bit 4 half-carry (H), bit 5 copy bit (Y), bit 6 zero (Z), bit 7 sign (S).

The operation codes on `op_sel` are:

| Code | Operation |
|------|-----------|
| 0 | rotate left circular |
| 1 | rotate left through carry |
| 2 | rotate right circular |
| 3 | rotate right through carry |
| 4 | complement accumulator |
| 5 | set carry |
| 6 | complement carry |
| 7 | no operation |

Top module: `accflag_unit`

## Requirements
- R1: Code 0 (rotate left circular) gives new accumulator = {A[6:0], A[7]} and sets carry (bit 0) to the old A[7].
- R2: Code 1 (rotate left through carry) gives new accumulator = {A[6:0], old carry} and sets carry to the old A[7].
- R3: Code 2 (rotate right circular) gives new accumulator = {A[0], A[7:1]} and sets carry to the old A[0].
- R4: Code 3 (rotate right through carry) gives new accumulator = {old carry, A[7:1]} and sets carry to the old A[0].
- R5: All four rotates clear N (bit 1) and H (bit 4), and load X (bit 3) and Y (bit 5) from bits 3 and 5 of the new accumulator.
- R6: Code 4 inverts all eight accumulator bits, sets N and H to 1, loads X and Y from bits 3 and 5 of the new accumulator, and keeps carry.
- R7: Code 5 sets carry to 1, clears N and H, and leaves the accumulator, X and Y unchanged.
- R8: Code 6 inverts carry, clears N, and loads H with the carry value held before the inversion; the accumulator, X and Y are unchanged.
- R9: For every operation code, S (bit 7), Z (bit 6) and PV (bit 2) of the result equal those of the input flag byte.
- R10: Code 7 returns the input accumulator and input flag byte unchanged.
- R11: Results are captured on the rising edge where `op_valid` is high and appear on the outputs after that edge. `res_valid` is high for exactly the cycle after each accepted operation. The outputs hold their values while `op_valid` is low, whatever the other inputs do.
- R12: A synchronous active-high reset clears `acc_out`, `flag_out` and `res_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; inputs are sampled when high |
| op_sel | input | 3 | Operation code, 0 to 7 |
| acc_in | input | 8 | Current accumulator |
| flag_in | input | 8 | Current flag byte |
| acc_out | output | 8 | Registered new accumulator |
| flag_out | output | 8 | Registered new flag byte |
| res_valid | output | 1 | High for one cycle after an accepted operation |

## Verification
Every result is due exactly one rising edge after the edge that sees `op_valid` high. `res_valid`, `acc_out` and `flag_out` change together on that edge. The driver applies inputs on the falling edge and pushes the expected accumulator and flags into a queue in the same step. The monitor samples on each following falling edge and pops one entry whenever `res_valid` is high. Any shift of a result by a cycle therefore shows up as a mismatch or as an entry left in the queue. Idle stretches with noisy inputs are checked on every falling edge against the last result, to confirm that the outputs hold.

// File: rtl/accflag_pkg.sv
package accflag_pkg;

    localparam int ACC_W  = 8;
    localparam int FLAG_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ROL_CIRC   = 3'd0,
        OP_ROL_CARRY  = 3'd1,
        OP_ROR_CIRC   = 3'd2,
        OP_ROR_CARRY  = 3'd3,
        OP_INVERT_ACC = 3'd4,
        OP_CARRY_SET  = 3'd5,
        OP_CARRY_FLIP = 3'd6,
        OP_NONE       = 3'd7
    } op_e;

    // Same bit layout as the ALU flag byte: MSB first.
    typedef struct packed {
        logic s;   // bit 7
        logic z;   // bit 6
        logic y;   // bit 5
        logic h;   // bit 4
        logic x;   // bit 3
        logic pv;  // bit 2
        logic n;   // bit 1
        logic c;   // bit 0
    } flags_t;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        flags_t           flg;
    } result_t;

    // The two copy bits follow bits 3 and 5 of the new accumulator.
    function automatic flags_t copy_bits(flags_t f, logic [ACC_W-1:0] a);
        flags_t r;
        r   = f;
        r.x = a[3];
        r.y = a[5];
        return r;
    endfunction

    function automatic logic is_rotate(op_e op);
        return (op == OP_ROL_CIRC) || (op == OP_ROL_CARRY) ||
               (op == OP_ROR_CIRC) || (op == OP_ROR_CARRY);
    endfunction

endpackage

// File: rtl/accflag_rotator.sv
module accflag_rotator
    import accflag_pkg::*;
(
    input  op_e              op,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             carry_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             carry_o
);

    logic             left;
    logic             through;
    logic             fill_bit;
    logic             out_bit;

    always_comb begin
        left    = (op == OP_ROL_CIRC) || (op == OP_ROL_CARRY);
        through = (op == OP_ROL_CARRY) || (op == OP_ROR_CARRY);
        out_bit = left ? acc_i[ACC_W-1] : acc_i[0];
        fill_bit = through ? carry_i : out_bit;
        if (left) begin
            acc_o = {acc_i[ACC_W-2:0], fill_bit};
        end else begin
            acc_o = {fill_bit, acc_i[ACC_W-1:1]};
        end
        carry_o = out_bit;
    end

endmodule

// File: rtl/accflag_flagctl.sv
module accflag_flagctl
    import accflag_pkg::*;
(
    input  op_e              op,
    input  logic [ACC_W-1:0] acc_i,
    input  flags_t           flg_i,
    input  logic [ACC_W-1:0] rot_acc,
    input  logic             rot_carry,
    output result_t          res_o
);

    always_comb begin
        res_o.acc = acc_i;
        res_o.flg = flg_i;
        if (is_rotate(op)) begin
            res_o.acc   = rot_acc;
            res_o.flg   = copy_bits(flg_i, rot_acc);
            res_o.flg.c = rot_carry;
            res_o.flg.n = 1'b0;
            res_o.flg.h = 1'b0;
        end else begin
            unique case (op)
                OP_INVERT_ACC: begin
                    res_o.acc   = ~acc_i;
                    res_o.flg   = copy_bits(flg_i, ~acc_i);
                    res_o.flg.n = 1'b1;
                    res_o.flg.h = 1'b1;
                end
                OP_CARRY_SET: begin
                    res_o.flg.c = 1'b1;
                    res_o.flg.n = 1'b0;
                    res_o.flg.h = 1'b0;
                end
                OP_CARRY_FLIP: begin
                    res_o.flg.c = ~flg_i.c;
                    res_o.flg.n = 1'b0;
                    res_o.flg.h = flg_i.c;
                end
                default: begin
                    res_o.acc = acc_i;
                    res_o.flg = flg_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/accflag_outreg.sv
module accflag_outreg
    import accflag_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  result_t d,
    output result_t q,
    output logic    vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/accflag_unit.sv
module accflag_unit
    import accflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [FLAG_W-1:0] flag_in,
    output logic [ACC_W-1:0]  acc_out,
    output logic [FLAG_W-1:0] flag_out,
    output logic              res_valid
);

    op_e              op;
    flags_t           flg;
    logic [ACC_W-1:0] rot_acc;
    logic             rot_carry;
    result_t          next_res;
    result_t          held_res;

    assign op  = op_e'(op_sel);
    assign flg = flags_t'(flag_in);

    accflag_rotator u_rot (
        .op      (op),
        .acc_i   (acc_in),
        .carry_i (flg.c),
        .acc_o   (rot_acc),
        .carry_o (rot_carry)
    );

    accflag_flagctl u_fc (
        .op        (op),
        .acc_i     (acc_in),
        .flg_i     (flg),
        .rot_acc   (rot_acc),
        .rot_carry (rot_carry),
        .res_o     (next_res)
    );

    accflag_outreg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (op_valid),
        .d    (next_res),
        .q    (held_res),
        .vld  (res_valid)
    );

    assign acc_out  = held_res.acc;
    assign flag_out = held_res.flg;

endmodule

// File: rtl/accflag_chk.sv
module accflag_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] flag_in,
    input logic [7:0] acc_out,
    input logic [7:0] flag_out,
    input logic       res_valid
);

    a_r1_rol_circ: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd0) |=>
            (acc_out == {$past(acc_in[6:0]), $past(acc_in[7])}) &&
            (flag_out[0] == $past(acc_in[7])));

    a_r2_rol_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd1) |=>
            (acc_out == {$past(acc_in[6:0]), $past(flag_in[0])}) &&
            (flag_out[0] == $past(acc_in[7])));

    a_r3_ror_circ: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd2) |=>
            (acc_out == {$past(acc_in[0]), $past(acc_in[7:1])}) &&
            (flag_out[0] == $past(acc_in[0])));

    a_r4_ror_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd3) |=>
            (acc_out == {$past(flag_in[0]), $past(acc_in[7:1])}) &&
            (flag_out[0] == $past(acc_in[0])));

    a_r5_rot_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[2] == 1'b0) |=>
            (flag_out[1] == 1'b0) && (flag_out[4] == 1'b0) &&
            (flag_out[3] == acc_out[3]) && (flag_out[5] == acc_out[5]));

    a_r6_invert: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd4) |=>
            (acc_out == ~$past(acc_in)) && (flag_out[1] && flag_out[4]) &&
            (flag_out[0] == $past(flag_in[0])));

    a_r7_carry_set: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd5) |=>
            (flag_out[0] && !flag_out[1] && !flag_out[4]) &&
            (acc_out == $past(acc_in)));

    a_r8_carry_flip: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd6) |=>
            (flag_out[0] == !$past(flag_in[0])) &&
            (flag_out[4] == $past(flag_in[0])) && !flag_out[1]);

    a_r9_keep_szp: assert property (@(posedge clk) disable iff (rst)
        op_valid |=>
            (flag_out[7:6] == $past(flag_in[7:6])) &&
            (flag_out[2] == $past(flag_in[2])));

    a_r10_noop: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd7) |=>
            (acc_out == $past(acc_in)) && (flag_out == $past(flag_in)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc_out) && $stable(flag_out) && !res_valid);

    a_r11_valid: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

endmodule

bind accflag_unit accflag_chk u_chk (.*);

// File: tb/sim_accflag_unit.sv
`timescale 1ns/1ps
module sim_accflag_unit;

    typedef struct {
        logic [7:0] acc;
        logic [7:0] flg;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] flag_in = 8'd0;
    logic [7:0] acc_out;
    logic [7:0] flag_out;
    logic       res_valid;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    logic done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    accflag_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .flag_in(flag_in), .acc_out(acc_out),
        .flag_out(flag_out), .res_valid(res_valid)
    );

    // Flag positions: C=0 N=1 PV=2 X=3 H=4 Y=5 Z=6 S=7.
    function automatic exp_t model(input logic [2:0] op, input logic [7:0] a,
                                   input logic [7:0] f);
        exp_t e;
        logic [7:0] na;
        logic [7:0] nf;
        logic       cin;
        cin = f[0];
        na  = a;
        nf  = f;
        case (op)
            3'd0: begin na = (a << 1) | (a >> 7);       nf[0] = a[7]; e.tag = "R1"; end
            3'd1: begin na = (a << 1) | {7'd0, cin};    nf[0] = a[7]; e.tag = "R2"; end
            3'd2: begin na = (a >> 1) | (a << 7);       nf[0] = a[0]; e.tag = "R3"; end
            3'd3: begin na = (a >> 1) | {cin, 7'd0};    nf[0] = a[0]; e.tag = "R4"; end
            3'd4: begin na = a ^ 8'hFF; nf[1] = 1'b1; nf[4] = 1'b1;   e.tag = "R6"; end
            3'd5: begin nf[0] = 1'b1; nf[1] = 1'b0; nf[4] = 1'b0;     e.tag = "R7"; end
            3'd6: begin nf[0] = !cin; nf[1] = 1'b0; nf[4] = cin;      e.tag = "R8"; end
            default: begin e.tag = "R10"; end
        endcase
        if (op < 3'd4) begin
            nf[1] = 1'b0;
            nf[4] = 1'b0;          // R5 flags of the rotates
        end
        if (op < 3'd5) begin
            nf[3] = na[3];
            nf[5] = na[5];
        end
        e.acc = na;
        e.flg = nf;
        return e;
    endfunction

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] f);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op;
        acc_in   = a;
        flag_in  = f;
        sb.push_back(model(op, a, f));
    endtask

    task automatic idle_hold(input int n);
        logic [7:0] ha;
        logic [7:0] hf;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel   = 3'd4;
        acc_in   = 8'h5A;
        flag_in  = 8'hC3;
        @(negedge clk);   // last pending result now visible
        ha = acc_out;
        hf = flag_out;
        for (int i = 0; i < n; i++) begin
            op_sel  = 3'(i);
            acc_in  = 8'(i * 37 + 11);
            flag_in = 8'(i * 91 + 5);
            @(negedge clk);
            check("R11 hold", {acc_out, flag_out}, {ha, hf});
            check("R11 no valid", {15'd0, res_valid}, 16'd0);
        end
    endtask

    // Monitor: one expected entry per res_valid cycle.
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R11 unexpected res_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {acc_out, flag_out}, {e.acc, e.flg});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 reset", {acc_out, flag_out}, 16'd0);
        check("R12 reset valid", {15'd0, res_valid}, 16'd0);
        // one cycle after release with a strobe present: nothing captured yet
        op_valid = 1'b1;
        op_sel   = 3'd4;
        acc_in   = 8'hFF;
        @(negedge clk);
        check("R12 reset ignores strobe", {acc_out, flag_out}, 16'd0);
        rst = 1'b0;
        op_valid = 1'b0;

        // R1..R4 rotate patterns, carry both ways, flags all ones / zeros
        drive(3'd0, 8'h80, 8'h00);
        drive(3'd0, 8'h01, 8'hFF);
        drive(3'd1, 8'h80, 8'h00);
        drive(3'd1, 8'h55, 8'h01);
        drive(3'd2, 8'h01, 8'h00);
        drive(3'd2, 8'hA4, 8'hFF);
        drive(3'd3, 8'h01, 8'h00);
        drive(3'd3, 8'h28, 8'hD5);
        idle_hold(3);
        // R5 copy bits: results with bits 3/5 set and cleared
        drive(3'd0, 8'h14, 8'h3A);
        drive(3'd2, 8'h50, 8'h12);
        // R6 complement
        drive(3'd4, 8'h00, 8'h00);
        drive(3'd4, 8'hD7, 8'hFF);
        drive(3'd4, 8'h28, 8'h01);
        // R7 set carry
        drive(3'd5, 8'h3C, 8'h00);
        drive(3'd5, 8'hC3, 8'hFF);
        // R8 complement carry
        drive(3'd6, 8'h99, 8'h00);
        drive(3'd6, 8'h66, 8'h01);
        drive(3'd6, 8'h12, 8'hFF);
        // R10 no-op code
        drive(3'd7, 8'hB6, 8'h4D);
        idle_hold(4);
        // R9 across all codes with S/Z/PV patterns
        for (int k = 0; k < 8; k++) begin
            drive(3'(k), 8'(k * 29 + 3), {k[0], k[1], 3'b101, k[2], 2'b10});
        end
        idle_hold(2);
        // longer scan of the rotates
        for (int k = 0; k < 64; k++) begin
            drive(3'(k % 4), 8'(k * 53 + 7), 8'(k * 19));
        end
        idle_hold(2);
        repeat (2) @(negedge clk);
        check("R11 queue drained", 16'(sb.size()), 16'd0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule